// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block recovers the bit rhythm of a serial CAN receive line. A programmable prescaler divides the system clock into time quanta. Each nominal bit is built from a one-quantum sync segment, a first phase segment that ends at the sample point, and a second phase segment. A falling edge on the line while the bus is idle restarts the bit (hard synchronisation). A falling edge during a frame shifts the bit boundary by at most the programmed jump width (resynchronisation).

The frame logic around the block receives a one-cycle strobe at each sample point, together with the sampled level and the level from the previous sample. It also receives a one-cycle strobe at the start of each bit, which is when it drives its next transmit bit. The frame logic supplies two status hints: the bus is idle, or the node is transmitting, along with the level it is driving. Timing is loaded through two configuration registers. These registers accept writes only while the block is held in its configuration mode.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, sample_point and tx_point are 0 and sampled_bit and sampled_bit_q are 1. While init_mode is 1, no strobe is produced, and the bit timing restarts from the sync segment once init_mode falls.
- R2: A write with cfg_we=1 loads register A when cfg_sel=0. Register A holds the prescale code in bits [5:0] and the jump width code in bits [7:6]. A write with cfg_sel=1 loads register B, which holds the phase-1 code in bits [3:0], the phase-2 code in bits [6:4] and the triple-sample enable in bit 7. Writes made while init_mode is 0 have no effect.
- R3: One time quantum lasts (prescale code + 1) clock cycles.
- R4: With no falling edge on rx, a bit lasts 1 + (phase-1 code + 1) + (phase-2 code + 1) quanta. tx_point is high for exactly one cycle per bit, in the cycle after the last phase-2 quantum ends.
- R5: sample_point is high for one cycle after the last phase-1 quantum ends. In that same cycle sampled_bit takes the new sample and sampled_bit_q takes the previous sampled_bit. Both hold their values at all other times.
- R6: rx passes through one register and is compared at quantum boundaries. When bus_idle=1, a falling level between two boundaries makes the quantum that just ended the sync segment, so the next sample point falls phase-1 code + 1 quanta later.
- R7: A falling edge found at the end of phase-1 quantum k (counting from 0) lengthens phase 1 by min(k+1, jump width code + 1) quanta.
- R8: A falling edge found in phase 2 with r quanta left after the current one ends the bit at once if r <= jump width code + 1. Otherwise it shortens phase 2 by jump width code + 1 quanta.
- R9: At most one resynchronisation takes place between two sample points. An edge is ignored for resynchronisation while transmitting=1 and tx_bit=0 (the node is driving dominant).
- R10: With triple sampling enabled, sampled_bit is the majority of the registered rx at the sample boundary and at the two quantum boundaries before it. With triple sampling disabled, sampled_bit is the registered rx at the sample boundary alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode | input | 1 | Configuration mode: holds timing and unlocks the registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects register A (0) or register B (1) |
| cfg_wdata | input | 8 | Configuration write data |
| rx | input | 1 | Serial receive line, 1 = recessive |
| bus_idle | input | 1 | Frame logic reports an idle bus |
| transmitting | input | 1 | Frame logic reports that this node is transmitting |
| tx_bit | input | 1 | Level this node is driving |
| sample_point | output | 1 | One-cycle strobe at the sample point |
| sampled_bit | output | 1 | Most recent sampled level |
| sampled_bit_q | output | 1 | Sampled level from the sample before |
| tx_point | output | 1 | One-cycle strobe at the start of each bit |

## Verification
A wrong segment counter or a wrong jump length moves the next sample_point or tx_point by at least one quantum, and the bench's every-cycle comparison catches that at the first strobe that follows. A corrupted stored sample or a faulty vote shows up in sampled_bit in the cycle after the sample boundary, and one bit later in sampled_bit_q. A configuration write that gets through outside configuration mode changes the measured bit period within two bits.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PH1  = 2'd1,
      SEG_PH2  = 2'd2
   } bt_seg_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
   parameter int REG_W = 8,
   parameter int BRP_W = 6,
   parameter int SJW_W = 2,
   parameter int TS1_W = 4,
   parameter int TS2_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_mode,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] reg_a,
   output logic [REG_W-1:0] reg_b,
   output logic [BRP_W-1:0] brp,
   output logic [SJW_W-1:0] sjw,
   output logic [TS1_W-1:0] ts1,
   output logic [TS2_W-1:0] ts2,
   output logic             triple
);
   localparam int SJW_LO = BRP_W;
   localparam int TS2_LO = TS1_W;
   localparam int TRI_AT = TS1_W + TS2_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= '0;
         reg_b <= '0;
      end else if (cfg_we && init_mode) begin
         if (cfg_sel) reg_b <= cfg_wdata;
         else         reg_a <= cfg_wdata;
      end
   end

   assign brp    = reg_a[BRP_W-1:0];
   assign sjw    = reg_a[SJW_LO +: SJW_W];
   assign ts1    = reg_b[TS1_W-1:0];
   assign ts2    = reg_b[TS2_LO +: TS2_W];
   assign triple = reg_b[TRI_AT];
endmodule

// File: rtl/can_bt_prescale.sv
module can_bt_prescale #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [BRP_W-1:0] brp,
   output logic             tick
);
   logic [BRP_W-1:0] div_cnt;
   logic             wrap;

   assign wrap = (div_cnt == brp);
   assign tick = wrap & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_cnt <= '0;
      else if (hold)   div_cnt <= '0;
      else if (wrap)   div_cnt <= '0;
      else             div_cnt <= div_cnt + BRP_W'(1);
   end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx,
   input  logic tick,
   input  logic smp_now,
   input  logic triple_on,
   output logic edge_fall,
   output logic sample_point,
   output logic sampled_bit,
   output logic sampled_bit_q
);
   import can_bt_pkg::*;

   logic       rx_q;
   logic [1:0] hist;
   logic       vote;

   generate
      if (TRIPLE_EN) begin : g_vote3
         assign vote = triple_on ? maj3(hist[1], hist[0], rx_q) : rx_q;
      end else begin : g_vote1
         assign vote = rx_q;
      end
   endgenerate

   assign edge_fall = hist[0] & ~rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q          <= 1'b1;
         hist          <= 2'b11;
         sample_point  <= 1'b0;
         sampled_bit   <= 1'b1;
         sampled_bit_q <= 1'b1;
      end else begin
         rx_q         <= rx;
         sample_point <= smp_now;
         if (tick) hist <= {hist[0], rx_q};
         if (smp_now) begin
            sampled_bit   <= vote;
            sampled_bit_q <= sampled_bit;
         end
      end
   end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq #(
   parameter int SJW_W = 2,
   parameter int TS1_W = 4,
   parameter int TS2_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic             edge_fall,
   input  logic             bus_idle,
   input  logic             transmitting,
   input  logic             tx_bit,
   input  logic [SJW_W-1:0] sjw,
   input  logic [TS1_W-1:0] ts1,
   input  logic [TS2_W-1:0] ts2,
   output logic             smp_now,
   output logic             tx_point
);
   import can_bt_pkg::*;

   localparam int SEG_MAX = (TS1_W > TS2_W) ? TS1_W : TS2_W;
   localparam int CNT_W   = SEG_MAX + SJW_W + 1;
   localparam int JW_W    = SJW_W + 1;

   bt_seg_e          seg;
   logic [CNT_W-1:0] cnt;
   logic [JW_W-1:0]  ext, shr, jw;
   logic [CNT_W-1:0] len1, len2, rem, late, jw_c;
   logic             synced, hard, resync_ok, end2;

   assign jw   = JW_W'(sjw) + JW_W'(1);
   assign jw_c = CNT_W'(jw);
   assign len1 = CNT_W'(ts1) + CNT_W'(1) + CNT_W'(ext);
   assign len2 = CNT_W'(ts2) + CNT_W'(1) - CNT_W'(shr);
   assign rem  = len2 - CNT_W'(1) - cnt;
   assign late = cnt + CNT_W'(1);

   assign hard      = edge_fall & bus_idle;
   assign resync_ok = edge_fall & ~synced & ~(transmitting & ~tx_bit);
   assign smp_now   = tick & ~hard & (seg == SEG_PH1) & ~resync_ok
                    & (cnt == len1 - CNT_W'(1));
   assign end2      = tick & ~hard & (seg == SEG_PH2)
                    & (resync_ok ? (rem <= jw_c) : (cnt == len2 - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg      <= SEG_SYNC;
         cnt      <= '0;
         ext      <= '0;
         shr      <= '0;
         synced   <= 1'b0;
         tx_point <= 1'b0;
      end else if (hold) begin
         seg      <= SEG_SYNC;
         cnt      <= '0;
         ext      <= '0;
         shr      <= '0;
         synced   <= 1'b0;
         tx_point <= 1'b0;
      end else begin
         tx_point <= end2;
         if (tick) begin
            if (hard) begin
               seg    <= SEG_PH1;
               cnt    <= '0;
               ext    <= '0;
               shr    <= '0;
               synced <= 1'b1;
            end else begin
               case (seg)
                  SEG_SYNC: begin
                     seg <= SEG_PH1;
                     cnt <= '0;
                  end
                  SEG_PH1: begin
                     if (resync_ok) begin
                        ext    <= (late < jw_c) ? late[JW_W-1:0] : jw;
                        synced <= 1'b1;
                        cnt    <= cnt + CNT_W'(1);
                     end else if (smp_now) begin
                        seg    <= SEG_PH2;
                        cnt    <= '0;
                        synced <= 1'b0;
                     end else begin
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  SEG_PH2: begin
                     if (end2) begin
                        seg    <= SEG_SYNC;
                        cnt    <= '0;
                        ext    <= '0;
                        shr    <= '0;
                        synced <= synced | resync_ok;
                     end else begin
                        if (resync_ok) begin
                           shr    <= jw;
                           synced <= 1'b1;
                        end
                        cnt <= cnt + CNT_W'(1);
                     end
                  end
                  default: seg <= SEG_SYNC;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int REG_W     = 8,
   parameter int BRP_W     = 6,
   parameter int SJW_W     = 2,
   parameter int TS1_W     = 4,
   parameter int TS2_W     = 3,
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_mode,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             rx,
   input  logic             bus_idle,
   input  logic             transmitting,
   input  logic             tx_bit,
   output logic             sample_point,
   output logic             sampled_bit,
   output logic             sampled_bit_q,
   output logic             tx_point
);
   initial begin
      if (BRP_W + SJW_W > REG_W)
         $fatal(1, "register A fields exceed REG_W");
      if (TS1_W + TS2_W + 1 > REG_W)
         $fatal(1, "register B fields exceed REG_W");
   end

   logic [REG_W-1:0] cfg_reg_a, cfg_reg_b;
   logic [BRP_W-1:0] brp;
   logic [SJW_W-1:0] sjw;
   logic [TS1_W-1:0] ts1;
   logic [TS2_W-1:0] ts2;
   logic             triple, tick, edge_fall, smp_now;

   can_bt_cfg #(.REG_W(REG_W), .BRP_W(BRP_W), .SJW_W(SJW_W),
                .TS1_W(TS1_W), .TS2_W(TS2_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .reg_a(cfg_reg_a),
      .reg_b(cfg_reg_b), .brp(brp), .sjw(sjw), .ts1(ts1), .ts2(ts2),
      .triple(triple));

   can_bt_prescale #(.BRP_W(BRP_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .hold(init_mode), .brp(brp), .tick(tick));

   can_bt_seq #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .hold(init_mode), .tick(tick),
      .edge_fall(edge_fall), .bus_idle(bus_idle),
      .transmitting(transmitting), .tx_bit(tx_bit), .sjw(sjw), .ts1(ts1),
      .ts2(ts2), .smp_now(smp_now), .tx_point(tx_point));

   can_bt_sampler #(.TRIPLE_EN(TRIPLE_EN)) u_smp (
      .clk(clk), .rst_n(rst_n), .rx(rx), .tick(tick), .smp_now(smp_now),
      .triple_on(triple), .edge_fall(edge_fall),
      .sample_point(sample_point), .sampled_bit(sampled_bit),
      .sampled_bit_q(sampled_bit_q));
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             init_mode,
   input logic             sample_point,
   input logic             tx_point,
   input logic             sampled_bit,
   input logic             sampled_bit_q,
   input logic [REG_W-1:0] reg_a,
   input logic [REG_W-1:0] reg_b
);
   assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_mode) |-> (!sample_point && !tx_point));

   assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(init_mode) |-> ($stable(reg_a) && $stable(reg_b)));

   assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_point |=> !tx_point);

   assert_smp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_point |=> !sample_point);

   assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_point && tx_point));

   assert_prev_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_point |-> (sampled_bit_q == $past(sampled_bit)));

   assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_point |-> ($stable(sampled_bit) && $stable(sampled_bit_q)));
endmodule

bind can_bit_timer can_bit_timer_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
   .sample_point(sample_point), .tx_point(tx_point),
   .sampled_bit(sampled_bit), .sampled_bit_q(sampled_bit_q),
   .reg_a(cfg_reg_a), .reg_b(cfg_reg_b));

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_mode = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       rx = 1'b1;
   logic       bus_idle = 1'b0;
   logic       transmitting = 1'b0;
   logic       tx_bit = 1'b1;
   logic       sample_point, sampled_bit, sampled_bit_q, tx_point;

   always #10 clk = ~clk;

   can_bit_timer i_can_bit_timer (
      .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rx(rx),
      .bus_idle(bus_idle), .transmitting(transmitting), .tx_bit(tx_bit),
      .sample_point(sample_point), .sampled_bit(sampled_bit),
      .sampled_bit_q(sampled_bit_q), .tx_point(tx_point));

   int    total = 0, bad = 0, cyc = 0;
   string req = "R1";

   task automatic chk(string r, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", r, what, act, exp, cyc);
      end
   endtask

   // behavioural reference: bit position counted in quanta from the sync quantum
   int m_a = 0, m_b = 0, m_pc = 0, m_pos = 0, m_ext = 0, m_shr = 0, m_syn = 0;
   int m_rxq = 1, m_h0 = 1, m_h1 = 1, m_sb = 1, m_sbq = 1, m_sp = 0, m_tx = 0;
   int brp_v, sjw_v, t1_v, t2_v, tr_v, jw_v, l1_v, l2_v, vote_v, n_sp, n_tx;
   bit tick_v, fall_v, ok_v;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_a = 0; m_b = 0; m_pc = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_syn = 0;
         m_rxq = 1; m_h0 = 1; m_h1 = 1; m_sb = 1; m_sbq = 1; m_sp = 0; m_tx = 0;
      end else begin
         brp_v = m_a % 64;        sjw_v = m_a / 64;
         t1_v  = m_b % 16;        t2_v  = (m_b / 16) % 8;  tr_v = m_b / 128;
         jw_v  = sjw_v + 1;
         tick_v = !init_mode && (m_pc == brp_v);
         fall_v = (m_h0 == 1) && (m_rxq == 0);
         n_sp = 0; n_tx = 0;
         if (tick_v) begin
            l1_v = t1_v + 1 + m_ext;
            l2_v = t2_v + 1 - m_shr;
            if (fall_v && bus_idle) begin
               m_pos = 1; m_ext = 0; m_shr = 0; m_syn = 1;
            end else begin
               ok_v = fall_v && (m_syn == 0) && !(transmitting && !tx_bit);
               if (m_pos == 0) m_pos = 1;
               else if (m_pos <= l1_v) begin
                  if (ok_v) begin
                     m_ext = (m_pos < jw_v) ? m_pos : jw_v;
                     m_syn = 1;
                  end else if (m_pos == l1_v) begin
                     n_sp = 1; m_syn = 0;
                  end
                  m_pos++;
               end else begin
                  if (ok_v) begin
                     m_syn = 1;
                     if (l1_v + l2_v - m_pos <= jw_v) n_tx = 1;
                     else begin m_shr = jw_v; m_pos++; end
                  end else if (m_pos == l1_v + l2_v) n_tx = 1;
                  else m_pos++;
                  if (n_tx == 1) begin m_pos = 0; m_ext = 0; m_shr = 0; end
               end
            end
         end
         if (tr_v == 1) vote_v = (m_h1 + m_h0 + m_rxq >= 2) ? 1 : 0;
         else           vote_v = m_rxq;
         if (n_sp == 1) begin m_sbq = m_sb; m_sb = vote_v; end
         if (tick_v) begin m_h1 = m_h0; m_h0 = m_rxq; end
         m_rxq = int'(rx);
         if (init_mode) begin
            m_pc = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_syn = 0;
         end else m_pc = (m_pc == brp_v) ? 0 : m_pc + 1;
         if (cfg_we && init_mode) begin
            if (cfg_sel) m_b = int'(cfg_wdata);
            else         m_a = int'(cfg_wdata);
         end
         m_sp = n_sp; m_tx = n_tx;
      end
   end

   always @(negedge clk) begin
      chk(req, "sample_point", int'(sample_point), m_sp);
      chk(req, "sampled_bit", int'(sampled_bit), m_sb);
      chk(req, "sampled_bit_q", int'(sampled_bit_q), m_sbq);
      chk(req, "tx_point", int'(tx_point), m_tx);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=<60000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(input bit s, input logic [7:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic drive(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input int exp, input string r);
      int t0;
      do @(negedge clk); while (!tx_point);
      t0 = cyc;
      do @(negedge clk); while (!tx_point);
      chk(r, "bit period", cyc - t0, exp);
   endtask

   logic [15:0] lf = 16'hACE1;

   task automatic random_run(input int n);
      for (int i = 0; i < n; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         rx = lf[0];
         bus_idle = (lf[4:2] == 3'd0);
         transmitting = lf[5];
         tx_bit = lf[6];
         repeat (1 + int'(lf[11:7]) % 20) @(negedge clk);
      end
      bus_idle = 1'b0; transmitting = 1'b0; tx_bit = 1'b1;
   endtask

   initial begin
      int strobes;
      repeat (3) @(negedge clk);
      chk("R1", "reset sample_point", int'(sample_point), 0);
      chk("R1", "reset tx_point", int'(tx_point), 0);
      chk("R1", "reset sampled_bit", int'(sampled_bit), 1);
      chk("R1", "reset sampled_bit_q", int'(sampled_bit_q), 1);
      rst_n = 1'b1;
      init_mode = 1'b1;
      req = "R2";
      wr(1'b0, 8'h41);           // prescale 1, jump width code 1
      wr(1'b1, 8'h23);           // phase1 code 3, phase2 code 2, single sample
      req = "R1";
      strobes = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         strobes += int'(sample_point) + int'(tx_point);
      end
      chk("R1", "strobes during init", strobes, 0);
      init_mode = 1'b0;

      req = "R4";
      measure(16, "R4");         // 8 quanta of 2 clocks
      req = "R2";
      wr(1'b0, 8'h45);           // must be ignored outside init
      measure(16, "R2");
      measure(16, "R2");

      req = "R3";
      @(negedge clk); init_mode = 1'b1;
      wr(1'b0, 8'h43);           // prescale 3
      @(negedge clk); init_mode = 1'b0;
      measure(32, "R3");
      @(negedge clk); init_mode = 1'b1;
      wr(1'b0, 8'h41);
      @(negedge clk); init_mode = 1'b0;

      req = "R6";
      bus_idle = 1'b1;
      drive(1'b1, 41); drive(1'b0, 16); drive(1'b1, 23);
      drive(1'b0, 5); drive(1'b1, 30);
      bus_idle = 1'b0;
      drive(1'b1, 40);

      req = "R7";
      repeat (8) begin drive(1'b0, 18); drive(1'b1, 18); end
      drive(1'b1, 40);
      req = "R8";
      repeat (8) begin drive(1'b0, 13); drive(1'b1, 13); end
      drive(1'b1, 40);

      req = "R9";
      transmitting = 1'b1; tx_bit = 1'b0;
      repeat (4) begin drive(1'b0, 18); drive(1'b1, 18); end
      tx_bit = 1'b1;
      repeat (4) begin drive(1'b0, 18); drive(1'b1, 18); end
      repeat (4) begin drive(1'b0, 3); drive(1'b1, 5); end
      transmitting = 1'b0;

      req = "R10";
      @(negedge clk); init_mode = 1'b1;
      wr(1'b1, 8'hA3);           // triple sampling on
      @(negedge clk); init_mode = 1'b0;
      repeat (12) begin drive(1'b1, 13); drive(1'b0, 2); end
      repeat (12) begin drive(1'b0, 15); drive(1'b1, 3); end
      drive(1'b1, 40);

      req = "R5";
      random_run(150);
      @(negedge clk); init_mode = 1'b1;
      wr(1'b0, 8'hC2);           // prescale 2, jump width code 3
      wr(1'b1, 8'h47);           // phase1 code 7, phase2 code 4, single sample
      @(negedge clk); init_mode = 1'b0;
      req = "R8";
      random_run(150);
      @(negedge clk); init_mode = 1'b1;
      wr(1'b1, 8'hB5);           // triple, phase1 5, phase2 3
      @(negedge clk); init_mode = 1'b0;
      req = "R10";
      random_run(150);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule